// File: doc/BRIEF.md
# Register-List Transfer Sequencer

This block carries out multi-register stack and block transfers for a processor core. It accepts a request that names one of four operations: push, pop, block store or block load. The request also carries an 8-bit list of low registers, a flag for one extra word, and a starting pointer. The block then runs one 32-bit word access per cycle over a simple valid/ready memory port.

For stores, the block reads register values through a combinational read port. For loads, it writes the returned data back through a write port. When the sequence is over, the block pulses `done_o` and presents the final pointer. For a push, the extra word is the link value. For a pop, the extra word is the new program counter. For the block operations, the flag is ignored.

The register file and the memory are outside the block. The block holds no more than one memory request at a time.

Top module: `regxfer_seq`

## Requirements
- R1: A request on `start_i` is taken only while `busy_o` is low. `busy_o` stays high from the cycle after acceptance through the done cycle. While idle, `mem_valid_o` is low, and a `start_i` pulse during a run does not change that run.
- R2: Push (`op_i`=0) walks the selected registers from 7 down to 0, where list bit n selects register n. Before each store the pointer drops by 4, and the store goes to the lowered pointer.
- R3: A push with the extra flag first stores `lr_i` at pointer−4, which is the highest address of the run, and only then stores the listed registers.
- R4: Pop (`op_i`=1) walks the selected registers from 0 up to 7. Each one loads from the current pointer, which then rises by 4. Each loaded word appears on `rf_we_o`/`rf_waddr_o`/`rf_wdata_o` in the cycle the read is accepted.
- R5: A pop with the extra flag loads the program counter last, from the address after the last register. The value appears on `pc_we_o`/`pc_o`.
- R6: Block store (`op_i`=2) stores the selected registers in ascending order, at the base and then at each following word. The final base is returned.
- R7: Block load (`op_i`=3) loads in ascending order with a post-increment base. For block store and block load, the extra flag has no effect on the accesses or on the final pointer.
- R8: An empty list with no effective extra word raises `done_o` in the cycle after acceptance. There is no memory access, and `ptr_o` equals the start pointer.
- R9: While `mem_valid_o` is high and `mem_ready_i` is low, the request stays up the next cycle with the same address, direction and store data.
- R10: `done_o` is high for exactly one cycle. In that cycle `ptr_o` equals the start pointer minus 4·N for push, or plus 4·N otherwise, where N is the number of words transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 push, 1 pop, 2 block store, 3 block load |
| list_i | input | 8 | Register select list, bit n = register n |
| extra_i | input | 1 | Link word (push) or program counter (pop) |
| base_i | input | 32 | Starting stack pointer or base |
| lr_i | input | 32 | Link value stored by push with extra |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ptr_o | output | 32 | Final pointer, valid with done_o |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_write_o | output | 1 | 1 store, 0 load |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with accepted read |
| rf_raddr_o | output | 3 | Register read index |
| rf_rdata_i | input | 32 | Register read data |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 3 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| pc_we_o | output | 1 | Program counter load |
| pc_o | output | 32 | New program counter |

## Verification
The hardest cases to reach are a memory stall that lands on the extra word. For push, that word comes first and uses the link value. For pop, it comes last and carries the program counter. Also hard are a fresh request that arrives while a run is still going, and a list that is empty apart from the extra flag. Directed runs build each of these cases directly. They are mixed with seeded random lists, operations and pointers, and the ready line drops at random so that every access position sees stalls.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;
  typedef enum logic [1:0] {
    XOP_PUSH  = 2'd0,
    XOP_POP   = 2'd1,
    XOP_STBLK = 2'd2,
    XOP_LDBLK = 2'd3
  } xop_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XFER = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_e;
endpackage

// File: rtl/regxfer_pick.sv
// Priority selector: lowest or highest set bit of a pending mask.
module regxfer_pick #(
  parameter int LIST_W  = 8,
  parameter bit DESCEND = 1'b0,
  localparam int IDX_W  = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] vec_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  generate
    if (DESCEND) begin : g_high
      always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < LIST_W; i++) begin
          if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
          end
        end
      end
    end else begin : g_low
      always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = LIST_W - 1; i >= 0; i--) begin
          if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/regxfer_count.sv
// Closed-form end pointer: start +/- STEP * (listed words + extra word).
module regxfer_count #(
  parameter int LIST_W = 8,
  parameter int DATA_W = 32,
  parameter int STEP   = 4,
  localparam int CNT_W = $clog2(LIST_W + 2)
) (
  input  logic [LIST_W-1:0] list_i,
  input  logic              extra_i,
  input  logic              down_i,
  input  logic [DATA_W-1:0] base_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] end_o
);
  logic [DATA_W-1:0] span;

  always_comb begin
    count_o = CNT_W'(extra_i);
    for (int i = 0; i < LIST_W; i++) begin
      count_o = count_o + CNT_W'(list_i[i]);
    end
    span  = DATA_W'(count_o) * DATA_W'(STEP);
    end_o = down_i ? (base_i - span) : (base_i + span);
  end
endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
  import regxfer_pkg::*;
#(
  parameter int LIST_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LIST_W),
  localparam int STEP  = DATA_W / 8,
  localparam int CNT_W = $clog2(LIST_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic              extra_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] lr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] ptr_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              pc_we_o,
  output logic [DATA_W-1:0] pc_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  sq_state_e         state_q, state_d;
  xop_e              op_q, op_d;
  logic [LIST_W-1:0] pend_q, pend_d;
  logic              extra_q, extra_d;
  logic [DATA_W-1:0] ptr_q, ptr_d;
  logic [DATA_W-1:0] final_q, final_d;
  logic              ctx_en;

  // request decode
  xop_e              op_req;
  logic              extra_eff;
  logic              req_down;
  logic              accept;
  logic [CNT_W-1:0]  req_count;
  logic [DATA_W-1:0] req_end;

  assign op_req    = xop_e'(op_i);
  assign extra_eff = extra_i & ((op_req == XOP_PUSH) | (op_req == XOP_POP));
  assign req_down  = (op_req == XOP_PUSH);
  assign accept    = (state_q == SQ_IDLE) & start_i;

  regxfer_count #(.LIST_W(LIST_W), .DATA_W(DATA_W), .STEP(STEP)) u_count (
    .list_i  (list_i),
    .extra_i (extra_eff),
    .down_i  (req_down),
    .base_i  (base_i),
    .count_o (req_count),
    .end_o   (req_end)
  );

  // next register in each walking direction
  logic             hi_found, lo_found;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  regxfer_pick #(.LIST_W(LIST_W), .DESCEND(1'b1)) u_pick_hi (
    .vec_i   (pend_q),
    .found_o (hi_found),
    .idx_o   (hi_idx)
  );

  regxfer_pick #(.LIST_W(LIST_W), .DESCEND(1'b0)) u_pick_lo (
    .vec_i   (pend_q),
    .found_o (lo_found),
    .idx_o   (lo_idx)
  );

  logic              is_push, is_store;
  logic              any_reg;
  logic [IDX_W-1:0]  sel_idx;
  logic              cur_extra;
  logic              fire;
  logic [LIST_W-1:0] sel_mask;

  assign is_push   = (op_q == XOP_PUSH);
  assign is_store  = (op_q == XOP_PUSH) | (op_q == XOP_STBLK);
  assign any_reg   = is_push ? hi_found : lo_found;
  assign sel_idx   = is_push ? hi_idx : lo_idx;
  // push: link word leads; pop: program counter trails the list
  assign cur_extra = is_push ? extra_q : (extra_q & ~any_reg);
  assign sel_mask  = LIST_W'(1) << sel_idx;

  // memory and register ports
  assign mem_valid_o = (state_q == SQ_XFER);
  assign mem_write_o = is_store;
  assign mem_addr_o  = is_push ? (ptr_q - DATA_W'(STEP)) : ptr_q;
  assign mem_wdata_o = cur_extra ? lr_i : rf_rdata_i;
  assign rf_raddr_o  = sel_idx;
  assign fire        = mem_valid_o & mem_ready_i;

  assign rf_we_o    = fire & ~is_store & ~cur_extra;
  assign rf_waddr_o = sel_idx;
  assign rf_wdata_o = mem_rdata_i;
  assign pc_we_o    = fire & ~is_store & cur_extra;
  assign pc_o       = mem_rdata_i;

  assign busy_o = (state_q != SQ_IDLE);
  assign done_o = (state_q == SQ_DONE);
  assign ptr_o  = ptr_q;

  // next state
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    pend_d  = pend_q;
    extra_d = extra_q;
    ptr_d   = ptr_q;
    final_d = final_q;
    ctx_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          ctx_en  = 1'b1;
          op_d    = op_req;
          pend_d  = list_i;
          extra_d = extra_eff;
          ptr_d   = base_i;
          final_d = req_end;
          state_d = (req_count == '0) ? SQ_DONE : SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (fire) begin
          ctx_en = 1'b1;
          if (cur_extra) extra_d = 1'b0;
          else           pend_d  = pend_q & ~sel_mask;
          ptr_d = is_push ? (ptr_q - DATA_W'(STEP)) : (ptr_q + DATA_W'(STEP));
          if ((pend_d == '0) && !extra_d) state_d = SQ_DONE;
        end
      end
      SQ_DONE: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= SQ_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q    <= XOP_PUSH;
      pend_q  <= '0;
      extra_q <= 1'b0;
      ptr_q   <= '0;
      final_q <= '0;
    end else if (ctx_en) begin
      op_q    <= op_d;
      pend_q  <= pend_d;
      extra_q <= extra_d;
      ptr_q   <= ptr_d;
      final_q <= final_d;
    end
  end

endmodule

// File: rtl/regxfer_seq_chk.sv
module regxfer_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] ptr_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_write_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              rf_we_o,
  input logic              pc_we_o,
  input logic [DATA_W-1:0] final_q
);
  // R1: nothing requested while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_valid_o);

  // R9: a stalled request is held unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_write_o) && $stable(mem_wdata_o)));

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: stepwise pointer agrees with the closed-form end pointer
  a_r10_final_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ptr_o == final_q));

  // R4 R5: write-backs only on an accepted read, never both targets
  a_r4_wb_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o || pc_we_o) |-> (mem_valid_o && mem_ready_i && !mem_write_o
      && !(rf_we_o && pc_we_o)));
endmodule

bind regxfer_seq regxfer_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ptr_o       (ptr_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_write_o (mem_write_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .rf_we_o     (rf_we_o),
  .pc_we_o     (pc_we_o),
  .final_q     (final_q)
);

// File: tb/tb_regxfer_seq.sv
`timescale 1ns/1ps
module tb_regxfer_seq;
  logic        clk, rst_n;
  logic        start_i, extra_i;
  logic [1:0]  op_i;
  logic [7:0]  list_i;
  logic [31:0] base_i, lr_i;
  logic        busy_o, done_o;
  logic [31:0] ptr_o;
  logic        mem_valid_o, mem_ready_i, mem_write_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [2:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, pc_we_o;
  logic [31:0] pc_o;

  regxfer_seq dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // models of the register file and the memory
  logic [31:0] regs_m [0:7];
  logic [31:0] mem_m  [0:255];
  assign rf_rdata_i  = regs_m[rf_raddr_o];
  assign mem_rdata_i = mem_m[mem_addr_o[9:2]];

  always @(posedge clk) begin
    if (rf_we_o) regs_m[rf_waddr_o] <= rf_wdata_o;
    if (mem_valid_o && mem_ready_i && mem_write_o) mem_m[mem_addr_o[9:2]] <= mem_wdata_o;
  end

  int checks = 0;
  int errors = 0;
  int ready_pct = 70;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected access list
  logic        exp_wr  [0:15];
  logic [31:0] exp_adr [0:15];
  logic [31:0] exp_dat [0:15];
  int          exp_reg [0:15];   // 0..7 register, 8 program counter
  int          exp_n;
  logic [31:0] exp_ptr;

  function automatic string req_of(input logic [1:0] op, input bit ext);
    case (op)
      2'd0: req_of = ext ? "R3" : "R2";
      2'd1: req_of = ext ? "R5" : "R4";
      2'd2: req_of = "R6";
      default: req_of = "R7";
    endcase
  endfunction

  task automatic build_expect(input logic [1:0] op, input logic [7:0] lst, input bit ext, input logic [31:0] base);
    logic [31:0] p;
    p = base;
    exp_n = 0;
    if (op == 2'd0) begin
      if (ext) begin
        p = p - 4;
        exp_wr[exp_n] = 1; exp_adr[exp_n] = p; exp_dat[exp_n] = lr_i; exp_reg[exp_n] = 8; exp_n++;
      end
      for (int r = 7; r >= 0; r--) if (lst[r]) begin
        p = p - 4;
        exp_wr[exp_n] = 1; exp_adr[exp_n] = p; exp_dat[exp_n] = regs_m[r]; exp_reg[exp_n] = r; exp_n++;
      end
    end else begin
      for (int r = 0; r < 8; r++) if (lst[r]) begin
        exp_wr[exp_n] = (op == 2'd2); exp_adr[exp_n] = p; exp_dat[exp_n] = regs_m[r];
        exp_reg[exp_n] = r; exp_n++;
        p = p + 4;
      end
      if (op == 2'd1 && ext) begin
        exp_wr[exp_n] = 0; exp_adr[exp_n] = p; exp_dat[exp_n] = '0; exp_reg[exp_n] = 8; exp_n++;
        p = p + 4;
      end
    end
    exp_ptr = p;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] lst, input bit ext,
                        input logic [31:0] base, input bit poke_busy);
    int k;
    bit held;
    logic [31:0] held_adr;
    string rq;
    rq = req_of(op, ext);
    build_expect(op, lst, ext, base);
    @(negedge clk);
    op_i = op; list_i = lst; extra_i = ext; base_i = base; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R1", {31'd0, busy_o}, 32'd1);
    k = 0;
    held = 0;
    held_adr = '0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      mem_ready_i = (($urandom % 100) < ready_pct);
      if (poke_busy && cyc == 1) begin
        // R1: a new request while busy must not disturb this run
        op_i = ~op; list_i = ~lst; base_i = base + 32'h40; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      #1;
      if (held) begin
        check(mem_valid_o && mem_addr_o == held_adr, "R9", mem_addr_o, held_adr);
        held = 0;
      end
      if (done_o) begin
        check(ptr_o == exp_ptr, "R10", ptr_o, exp_ptr);
        check(k == exp_n, rq, k, exp_n);
        if (exp_n == 0) check(ptr_o == base && cyc == 0, "R8", ptr_o, base);
        break;
      end
      if (mem_valid_o && mem_ready_i) begin
        if (k >= exp_n) begin
          check(1'b0, rq, k, exp_n);
        end else begin
          check(mem_write_o == exp_wr[k] && mem_addr_o == exp_adr[k], rq, mem_addr_o, exp_adr[k]);
          if (exp_wr[k])
            check(mem_wdata_o == exp_dat[k], rq, mem_wdata_o, exp_dat[k]);
          else if (exp_reg[k] == 8)
            check(pc_we_o && !rf_we_o && pc_o == mem_m[exp_adr[k][9:2]], "R5", pc_o, mem_m[exp_adr[k][9:2]]);
          else
            check(rf_we_o && !pc_we_o && rf_waddr_o == 3'(exp_reg[k]) && rf_wdata_o == mem_m[exp_adr[k][9:2]],
                  rq, {29'd0, rf_waddr_o}, exp_reg[k]);
        end
        k++;
      end else if (mem_valid_o) begin
        held = 1;
        held_adr = mem_addr_o;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    check(!done_o && !busy_o && !mem_valid_o, "R10", {31'd0, done_o}, 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 8; i++) regs_m[i] = 32'h1000_0000 + i * 32'h0101_0101;
    for (int i = 0; i < 256; i++) mem_m[i] = 32'hA000_0000 ^ (i * 32'h0001_0003);
    rst_n = 1'b0; start_i = 0; op_i = 0; list_i = 0; extra_i = 0;
    base_i = 0; lr_i = 32'hCAFE_0001; mem_ready_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !mem_valid_o, "R1", {31'd0, busy_o}, 32'd0);

    // directed corners
    run_op(2'd0, 8'h00, 0, 32'h200, 0);   // R8 empty push
    run_op(2'd1, 8'h00, 0, 32'h200, 0);   // R8 empty pop
    run_op(2'd2, 8'h00, 1, 32'h200, 0);   // R8 R7 extra ignored on block store
    run_op(2'd0, 8'h00, 1, 32'h240, 0);   // R3 link only
    run_op(2'd0, 8'hA5, 1, 32'h280, 0);   // R3 R2
    run_op(2'd1, 8'hA5, 1, 32'h25C, 0);   // R5 R4
    run_op(2'd1, 8'h00, 1, 32'h260, 0);   // R5 pc only
    run_op(2'd2, 8'h81, 1, 32'h300, 0);   // R6
    run_op(2'd3, 8'hFF, 1, 32'h300, 0);   // R7
    ready_pct = 30;
    run_op(2'd0, 8'hFF, 1, 32'h2C0, 1);   // R1 start while busy, R9 stalls
    run_op(2'd1, 8'hFF, 1, 32'h29C, 0);
    ready_pct = 70;

    // random mix
    for (int t = 0; t < 80; t++) begin
      lr_i = $urandom;
      run_op(2'($urandom % 4), 8'($urandom), 1'($urandom), 32'h200 + 4 * ($urandom % 64), ($urandom % 8) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule